// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the per-line bookkeeping of a set-associative cache. It holds no data. For every way of every set it stores an occupied bit, the line address, a permission state and an optional lock owner. It also keeps a least-recently-used order for each set. A cache controller issues one command per cycle: look up a line with an access-type check, test for room, allocate, free, pick a victim, refresh recency, handle the lock, change the permission, or inspect a slot by flat index. The answer comes back on a registered response port.

The set count is the cache size divided by the associativity and by the line size. The set index is a field of the address that begins at a configurable bit. Addresses must be line-aligned. A hit needs a stored tag match whose permission is not the absent state. One query variant ignores the permission. Access is granted by comparing the permission with the request type.

Top module: `tag_directory`

## Requirements
- R1: After reset every slot is empty. Every flat-index readback returns address 0 with ok low. A victim probe on any set reports an error. In the recency order, way w has age w.
- R2: PRESENT (op 1) reports ok and the lowest matching way only when an occupied way holds the line and its permission is not ABSENT (code 0). PRESENT_ANY (op 2) reports any occupied tag match, whatever its permission.
- R3: ACCESS (op 0) is granted when the hit line is READ_WRITE (code 3), for any request. A READ_ONLY (code 2) line is granted only for LOAD (req 0) or FETCH (req 1); STORE is req 2 and ATOMIC is req 3. Every other case returns ok low.
- R4: A tag hit from ACCESS (op 0) or TOUCH (op 7) makes that way the youngest in its set, even when ACCESS is denied. A miss changes no recency.
- R5: AVAIL (op 3) is true when an occupied way holds the line with any permission, or when some way is empty or ABSENT.
- R6: ALLOC (op 4) uses the lowest way that is empty or ABSENT. It stores the line with permission INVALID (code 1) and no lock owner, and returns that way. It refreshes recency only when cmd_touch is high.
- R7: ALLOC of a line that already hits, or into a set with no empty or ABSENT way, returns an error and changes nothing.
- R8: FREE (op 5) empties the hit way so that later allocations can use it. A miss returns an error.
- R9: PROBE (op 6) on a full set returns the oldest way and its stored address. Ties go to the lowest way. On a set that is not full it returns an error and address 0.
- R10: LOCK (op 8) stores cmd_ctx as the owner of the hit line and UNLOCK (op 9) clears the owner. LOCKED (op 10) is true only when an owner is stored and equals cmd_ctx. All three report an error on a miss.
- R11: READ_IDX (op 11) decodes cmd_index as set × WAYS + way. It returns the stored line address when the slot is occupied and its permission is READ_ONLY, READ_WRITE or BUSY (code 4); otherwise it returns 0.
- R12: SET_PERM (op 12) writes cmd_perm into the lowest occupied tag match and reports an error on a miss. IS_BUSY (op 13) and IS_INVALID (op 14) are true only for an occupied slot, addressed by flat index, in state BUSY or INVALID respectively.
- R13: Each command is answered exactly one cycle later, and rsp_ok and rsp_err are never both high. Op 15, or a command whose address is not line-aligned, returns an error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | ADDR_W | Line-aligned address |
| cmd_req | input | 2 | Request type for ACCESS |
| cmd_ctx | input | CTX_W | Lock owner context |
| cmd_perm | input | 3 | New permission for SET_PERM |
| cmd_touch | input | 1 | ALLOC also refreshes recency |
| cmd_index | input | IDX_W | Flat slot index |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Boolean result of the command |
| rsp_err | output | 1 | Command refused or invalid |
| rsp_way | output | WAY_W | Hit, allocated or victim way, else 0 |
| rsp_addr | output | ADDR_W | Victim or readback address, else 0 |

## Verification
Every result, including the effect of a command on later commands, is visible in the response registered at the first rising edge after the command is driven. The bench drives each command on a falling edge and compares the response on the next falling edge, one rising edge later. State changes are confirmed by later commands whose expected values come from the bench's own model. Recency effects are seen through PROBE answers, and the absence of a response after an idle cycle is checked directly.

// File: rtl/tagdir_pkg.sv
`timescale 1ns/1ps
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_ABSENT  = 3'd0,
        PERM_INVALID = 3'd1,
        PERM_RDONLY  = 3'd2,
        PERM_RDWR    = 3'd3,
        PERM_BUSY    = 3'd4
    } perm_e;

    typedef enum logic [1:0] {
        REQ_LOAD   = 2'd0,
        REQ_FETCH  = 2'd1,
        REQ_STORE  = 2'd2,
        REQ_ATOMIC = 2'd3
    } req_e;

    typedef enum logic [3:0] {
        OP_ACCESS      = 4'd0,
        OP_PRESENT     = 4'd1,
        OP_PRESENT_ANY = 4'd2,
        OP_AVAIL       = 4'd3,
        OP_ALLOC       = 4'd4,
        OP_FREE        = 4'd5,
        OP_PROBE       = 4'd6,
        OP_TOUCH       = 4'd7,
        OP_LOCK        = 4'd8,
        OP_UNLOCK      = 4'd9,
        OP_LOCKED      = 4'd10,
        OP_READ_IDX    = 4'd11,
        OP_SET_PERM    = 4'd12,
        OP_IS_BUSY     = 4'd13,
        OP_IS_INVALID  = 4'd14,
        OP_RESERVED    = 4'd15
    } op_e;

    // Permission versus request type.
    function automatic logic access_granted(input perm_e p, input req_e r);
        logic g;
        g = 1'b0;
        if (p == PERM_RDWR)
            g = 1'b1;
        else if (p == PERM_RDONLY && (r == REQ_LOAD || r == REQ_FETCH))
            g = 1'b1;
        return g;
    endfunction

    // A slot whose line may be reported by flat-index readback.
    function automatic logic perm_readable(input perm_e p);
        return (p != PERM_ABSENT) && (p != PERM_INVALID);
    endfunction

    // Index of the lowest set bit, 0 when none is set.
    function automatic int unsigned lowest_one(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--)
            if (v[i]) r = i;
        return r;
    endfunction

endpackage

// File: rtl/tagdir_way_match.sv
`timescale 1ns/1ps
module tagdir_way_match
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int LINE_W = 26
) (
    input  logic [WAYS-1:0]             way_valid,
    input  perm_e [WAYS-1:0]            way_perm,
    input  logic [WAYS-1:0][LINE_W-1:0] way_line,
    input  logic [LINE_W-1:0]           probe_line,
    output logic [WAYS-1:0]             hit_vec,
    output logic [WAYS-1:0]             match_vec,
    output logic [WAYS-1:0]             free_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic tag_eq;
        assign tag_eq       = way_valid[w] && (way_line[w] == probe_line);
        assign match_vec[w] = tag_eq;
        assign hit_vec[w]   = tag_eq && (way_perm[w] != PERM_ABSENT);
        assign free_vec[w]  = !way_valid[w] || (way_perm[w] == PERM_ABSENT);
    end
endmodule

// File: rtl/tagdir_lru.sv
`timescale 1ns/1ps
module tagdir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     touch_en,
    input  logic [$clog2(SETS)-1:0]  touch_set,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    input  logic [$clog2(SETS)-1:0]  query_set,
    output logic [$clog2(WAYS)-1:0]  victim_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] age [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + 1'b1;
            end
        end
    end

    // Oldest way wins; strict compare keeps the lowest index on ties.
    always_comb begin
        victim_way = '0;
        for (int w = 1; w < WAYS; w++)
            if (age[query_set][w] > age[query_set][victim_way])
                victim_way = WAY_W'(w);
    end
endmodule

// File: rtl/tag_directory.sv
`timescale 1ns/1ps
module tag_directory
    import tagdir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int START_BIT   = 6,
    parameter int CTX_W       = 4,
    localparam int SETS   = CACHE_BYTES / WAYS / LINE_BYTES,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(SETS * WAYS),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_req,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic [2:0]        cmd_perm,
    input  logic              cmd_touch,
    input  logic [IDX_W-1:0]  cmd_index,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr
);
    // ---------------- slot storage ----------------
    logic              st_valid [SETS][WAYS];
    logic [LINE_W-1:0] st_line  [SETS][WAYS];
    perm_e             st_perm  [SETS][WAYS];
    logic              st_held  [SETS][WAYS];
    logic [CTX_W-1:0]  st_ctx   [SETS][WAYS];

    // ---------------- command decode ----------------
    op_e               op;
    req_e              req;
    logic [SET_W-1:0]  set_idx;
    logic [LINE_W-1:0] cmd_line;
    logic              misaligned;
    logic [SET_W-1:0]  idx_set;
    logic [WAY_W-1:0]  idx_way;

    assign op         = op_e'(cmd_op);
    assign req        = req_e'(cmd_req);
    assign set_idx    = cmd_addr[START_BIT +: SET_W];
    assign cmd_line   = cmd_addr[ADDR_W-1:OFF_W];
    assign misaligned = |cmd_addr[OFF_W-1:0];
    assign idx_set    = cmd_index[IDX_W-1:WAY_W];
    assign idx_way    = cmd_index[WAY_W-1:0];

    // ---------------- selected set view ----------------
    logic [WAYS-1:0]             sel_valid;
    perm_e [WAYS-1:0]            sel_perm;
    logic [WAYS-1:0][LINE_W-1:0] sel_line;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            sel_valid[w] = st_valid[set_idx][w];
            sel_perm[w]  = st_perm[set_idx][w];
            sel_line[w]  = st_line[set_idx][w];
        end
    end

    logic [WAYS-1:0] hit_vec, match_vec, free_vec;

    tagdir_way_match #(.WAYS(WAYS), .LINE_W(LINE_W)) u_match (
        .way_valid  (sel_valid),
        .way_perm   (sel_perm),
        .way_line   (sel_line),
        .probe_line (cmd_line),
        .hit_vec    (hit_vec),
        .match_vec  (match_vec),
        .free_vec   (free_vec)
    );

    logic             any_hit, any_match, any_free;
    logic [WAY_W-1:0] hit_way, match_way, free_way, victim_way;

    assign any_hit   = |hit_vec;
    assign any_match = |match_vec;
    assign any_free  = |free_vec;
    assign hit_way   = WAY_W'(lowest_one(32'(hit_vec)));
    assign match_way = WAY_W'(lowest_one(32'(match_vec)));
    assign free_way  = WAY_W'(lowest_one(32'(free_vec)));

    // ---------------- recency ----------------
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_set  (set_idx),
        .touch_way  (touch_way),
        .query_set  (set_idx),
        .victim_way (victim_way)
    );

    // ---------------- flat-index slot view ----------------
    logic  idx_valid;
    perm_e idx_perm;
    assign idx_valid = st_valid[idx_set][idx_way];
    assign idx_perm  = st_perm[idx_set][idx_way];

    // ---------------- operation logic ----------------
    logic              r_ok, r_err;
    logic [WAY_W-1:0]  r_way;
    logic [ADDR_W-1:0] r_addr;
    logic wr_alloc, wr_free, wr_lock, wr_unlock, wr_perm;

    always_comb begin
        r_ok      = 1'b0;
        r_err     = 1'b0;
        r_way     = '0;
        r_addr    = '0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        wr_alloc  = 1'b0;
        wr_free   = 1'b0;
        wr_lock   = 1'b0;
        wr_unlock = 1'b0;
        wr_perm   = 1'b0;
        if (cmd_valid) begin
            if (misaligned) begin
                r_err = 1'b1;
            end else begin
                unique case (op)
                    OP_ACCESS: begin
                        if (any_hit) begin
                            touch_en = 1'b1;
                            r_way    = hit_way;
                            r_ok     = access_granted(sel_perm[hit_way], req);
                        end
                    end
                    OP_PRESENT: begin
                        r_ok  = any_hit;
                        r_way = any_hit ? hit_way : '0;
                    end
                    OP_PRESENT_ANY: begin
                        r_ok  = any_match;
                        r_way = any_match ? match_way : '0;
                    end
                    OP_AVAIL: begin
                        r_ok = any_match || any_free;
                    end
                    OP_ALLOC: begin
                        if (any_hit || !any_free) begin
                            r_err = 1'b1;
                        end else begin
                            r_ok      = 1'b1;
                            r_way     = free_way;
                            wr_alloc  = 1'b1;
                            touch_en  = cmd_touch;
                            touch_way = free_way;
                        end
                    end
                    OP_FREE: begin
                        r_ok    = any_hit;
                        r_err   = !any_hit;
                        wr_free = any_hit;
                    end
                    OP_PROBE: begin
                        if (any_free) begin
                            r_err = 1'b1;
                        end else begin
                            r_ok   = 1'b1;
                            r_way  = victim_way;
                            r_addr = {sel_line[victim_way], {OFF_W{1'b0}}};
                        end
                    end
                    OP_TOUCH: begin
                        r_ok     = any_hit;
                        touch_en = any_hit;
                    end
                    OP_LOCK: begin
                        r_ok    = any_hit;
                        r_err   = !any_hit;
                        wr_lock = any_hit;
                    end
                    OP_UNLOCK: begin
                        r_ok      = any_hit;
                        r_err     = !any_hit;
                        wr_unlock = any_hit;
                    end
                    OP_LOCKED: begin
                        r_err = !any_hit;
                        r_ok  = any_hit && st_held[set_idx][hit_way]
                                && (st_ctx[set_idx][hit_way] == cmd_ctx);
                    end
                    OP_READ_IDX: begin
                        r_ok = idx_valid && perm_readable(idx_perm);
                        if (r_ok)
                            r_addr = {st_line[idx_set][idx_way], {OFF_W{1'b0}}};
                    end
                    OP_SET_PERM: begin
                        r_ok    = any_match;
                        r_err   = !any_match;
                        wr_perm = any_match;
                    end
                    OP_IS_BUSY: begin
                        r_ok = idx_valid && (idx_perm == PERM_BUSY);
                    end
                    OP_IS_INVALID: begin
                        r_ok = idx_valid && (idx_perm == PERM_INVALID);
                    end
                    default: begin
                        r_err = 1'b1;
                    end
                endcase
            end
        end
    end

    // ---------------- state update ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_valid[s][w] <= 1'b0;
                    st_line[s][w]  <= '0;
                    st_perm[s][w]  <= PERM_ABSENT;
                    st_held[s][w]  <= 1'b0;
                    st_ctx[s][w]   <= '0;
                end
            end
        end else begin
            if (wr_alloc) begin
                st_valid[set_idx][free_way] <= 1'b1;
                st_line[set_idx][free_way]  <= cmd_line;
                st_perm[set_idx][free_way]  <= PERM_INVALID;
                st_held[set_idx][free_way]  <= 1'b0;
            end
            if (wr_free)
                st_valid[set_idx][hit_way] <= 1'b0;
            if (wr_lock) begin
                st_held[set_idx][hit_way] <= 1'b1;
                st_ctx[set_idx][hit_way]  <= cmd_ctx;
            end
            if (wr_unlock)
                st_held[set_idx][hit_way] <= 1'b0;
            if (wr_perm)
                st_perm[set_idx][match_way] <= perm_e'(cmd_perm);
        end
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_way   <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_ok    <= r_ok;
            rsp_err   <= r_err;
            rsp_way   <= r_way;
            rsp_addr  <= r_addr;
        end
    end
endmodule

// File: rtl/tagdir_checker.sv
`timescale 1ns/1ps
module tagdir_checker
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_err,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [ADDR_W-1:0] rsp_addr
);
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    a_r13_rsp_after_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    a_r13_idle_no_rsp: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    a_r13_ok_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_ok && rsp_err));

    a_r7_alloc_one_outcome: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ALLOC) |=> (rsp_ok != rsp_err));

    a_r11_readback_aligned: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_READ_IDX) |=>
            (rsp_addr[OFF_W-1:0] == '0 && !rsp_err));

    a_r9_probe_err_no_addr: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROBE) |=>
            (!rsp_err || (rsp_addr == '0 && rsp_way == '0)));
endmodule

bind tag_directory tagdir_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .WAY_W  (WAY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_err   (rsp_err),
    .rsp_way   (rsp_way),
    .rsp_addr  (rsp_addr)
);

// File: tb/tag_directory_test.sv
`timescale 1ns/1ps
module tag_directory_test;
    localparam int ADDR_W = 32, LINE_BYTES = 64, CACHE_BYTES = 1024;
    localparam int WAYS = 4, START_BIT = 6, CTX_W = 4;
    localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS * WAYS);

    logic              clk = 1'b0, rst = 1'b1;
    logic              cmd_valid = 1'b0, cmd_touch = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0]        cmd_req = '0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic [2:0]        cmd_perm = '0;
    logic [IDX_W-1:0]  cmd_index = '0;
    logic              rsp_valid, rsp_ok, rsp_err;
    logic [WAY_W-1:0]  rsp_way;
    logic [ADDR_W-1:0] rsp_addr;

    always #2.5 clk = ~clk;

    tag_directory uut (.*);

    int n_checks = 0, n_fail = 0;

    // bench model
    bit          m_valid [SETS][WAYS];
    int          m_perm  [SETS][WAYS];
    logic [31:0] m_addr  [SETS][WAYS];
    bit          m_held  [SETS][WAYS];
    int          m_ctx   [SETS][WAYS];
    int          m_age   [SETS][WAYS];

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_perm[s][w] = 0; m_addr[s][w] = 0;
                m_held[s][w] = 0;  m_ctx[s][w] = 0;  m_age[s][w] = w;
            end
    endtask

    task automatic model_touch(int s, int w);
        int a0 = m_age[s][w];
        for (int k = 0; k < WAYS; k++)
            if (k != w && m_age[s][k] < a0) m_age[s][k]++;
        m_age[s][w] = 0;
    endtask

    function automatic string op_tag(int op);
        case (op)
            0: return "R3";  1, 2: return "R2"; 3: return "R5";
            4: return "R6";  5: return "R8";    6: return "R9";
            7: return "R4";  8, 9, 10: return "R10"; 11: return "R11";
            12, 13, 14: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(string tag, bit c, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run(int op, logic [31:0] a, int req, int ctx, int perm,
                       bit touch, int idx, string tag);
        int s = int'(a[START_BIT +: SET_W]);
        int si = idx / WAYS, wi = idx % WAYS;
        int hit = -1, anym = -1, fr = -1, vic = 0;
        bit e_ok = 0, e_err = 0;
        int e_way = 0;
        logic [31:0] e_addr = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_valid[s][w] && m_addr[s][w] == a) begin
                anym = w;
                if (m_perm[s][w] != 0) hit = w;
            end
            if (!m_valid[s][w] || m_perm[s][w] == 0) fr = w;
        end
        for (int w = 1; w < WAYS; w++) if (m_age[s][w] > m_age[s][vic]) vic = w;
        if (a[5:0] != 0) e_err = 1;
        else case (op)
            0: if (hit >= 0) begin
                   model_touch(s, hit); e_way = hit;
                   e_ok = (m_perm[s][hit] == 3) || (m_perm[s][hit] == 2 && req <= 1);
               end
            1: begin e_ok = hit >= 0; e_way = e_ok ? hit : 0; end
            2: begin e_ok = anym >= 0; e_way = e_ok ? anym : 0; end
            3: e_ok = (anym >= 0) || (fr >= 0);
            4: if (hit >= 0 || fr < 0) e_err = 1;
               else begin
                   e_ok = 1; e_way = fr;
                   m_valid[s][fr] = 1; m_addr[s][fr] = a; m_perm[s][fr] = 1;
                   m_held[s][fr] = 0;
                   if (touch) model_touch(s, fr);
               end
            5: if (hit >= 0) begin e_ok = 1; m_valid[s][hit] = 0; end else e_err = 1;
            6: if (fr >= 0) e_err = 1;
               else begin e_ok = 1; e_way = vic; e_addr = m_addr[s][vic]; end
            7: if (hit >= 0) begin e_ok = 1; model_touch(s, hit); end
            8: if (hit >= 0) begin e_ok = 1; m_held[s][hit] = 1; m_ctx[s][hit] = ctx; end
               else e_err = 1;
            9: if (hit >= 0) begin e_ok = 1; m_held[s][hit] = 0; end else e_err = 1;
            10: if (hit >= 0) e_ok = m_held[s][hit] && m_ctx[s][hit] == ctx;
                else e_err = 1;
            11: begin
                    e_ok = m_valid[si][wi] && m_perm[si][wi] >= 2;
                    e_addr = e_ok ? m_addr[si][wi] : 0;
                end
            12: if (anym >= 0) begin e_ok = 1; m_perm[s][anym] = perm; end
                else e_err = 1;
            13: e_ok = m_valid[si][wi] && m_perm[si][wi] == 4;
            14: e_ok = m_valid[si][wi] && m_perm[si][wi] == 1;
            default: e_err = 1;
        endcase
        @(negedge clk);
        cmd_valid = 1; cmd_op = 4'(op); cmd_addr = a; cmd_req = 2'(req);
        cmd_ctx = CTX_W'(ctx); cmd_perm = 3'(perm); cmd_touch = touch;
        cmd_index = IDX_W'(idx);
        @(negedge clk);
        cmd_valid = 0;
        check(tag, rsp_valid && rsp_ok == e_ok && rsp_err == e_err &&
                   int'(rsp_way) == e_way && rsp_addr == e_addr,
              {rsp_valid, rsp_ok, rsp_err, 5'(rsp_way), rsp_addr},
              {1'b1, e_ok, e_err, 5'(e_way), e_addr});
    endtask

    function automatic logic [31:0] L(int t, int s);
        return 32'((t << 8) | (s << 6));
    endfunction

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog got=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", !rsp_valid, 64'(rsp_valid), 64'd0);
        for (int i = 0; i < SETS * WAYS; i++) run(11, 0, 0, 0, 0, 0, i, "R1");
        run(6, L(1, 0), 0, 0, 0, 0, 0, "R1");
        // R6/R4: fill set 0 with touch, then recency through probe
        for (int t = 1; t <= 4; t++) run(4, L(t, 0), 0, 0, 0, 1, 0, "R6");
        run(6, L(1, 0), 0, 0, 0, 0, 0, "R9");
        run(4, L(9, 0), 0, 0, 0, 0, 0, "R7");   // full set
        run(4, L(2, 0), 0, 0, 0, 0, 0, "R7");   // already present
        run(0, L(1, 0), 2, 0, 0, 0, 0, "R3");   // Invalid: denied, but refreshes
        run(6, L(1, 0), 0, 0, 0, 0, 0, "R4");
        run(12, L(2, 0), 0, 0, 2, 0, 0, "R12");
        run(0, L(2, 0), 0, 0, 0, 0, 0, "R3");
        run(0, L(2, 0), 2, 0, 0, 0, 0, "R3");
        run(12, L(3, 0), 0, 0, 3, 0, 0, "R12");
        run(0, L(3, 0), 3, 0, 0, 0, 0, "R3");
        run(11, 0, 0, 0, 0, 0, 2, "R11");
        run(11, 0, 0, 0, 0, 0, 0, "R11");
        run(12, L(4, 0), 0, 0, 4, 0, 0, "R12");
        run(13, 0, 0, 0, 0, 0, 3, "R12");
        run(14, 0, 0, 0, 0, 0, 0, "R12");
        run(12, L(4, 0), 0, 0, 0, 0, 0, "R12");  // to absent
        run(1, L(4, 0), 0, 0, 0, 0, 0, "R2");
        run(2, L(4, 0), 0, 0, 0, 0, 0, "R2");
        run(3, L(9, 0), 0, 0, 0, 0, 0, "R5");
        run(4, L(9, 0), 0, 0, 0, 0, 0, "R6");   // reuses absent way 3
        run(3, L(7, 0), 0, 0, 0, 0, 0, "R5");
        run(8, L(2, 0), 0, 5, 0, 0, 0, "R10");
        run(10, L(2, 0), 0, 5, 0, 0, 0, "R10");
        run(10, L(2, 0), 0, 6, 0, 0, 0, "R10");
        run(9, L(2, 0), 0, 0, 0, 0, 0, "R10");
        run(10, L(2, 0), 0, 0, 0, 0, 0, "R10");
        run(8, L(7, 0), 0, 1, 0, 0, 0, "R10");
        run(5, L(1, 0), 0, 0, 0, 0, 0, "R8");
        run(5, L(1, 0), 0, 0, 0, 0, 0, "R8");
        run(4, L(7, 0), 0, 0, 0, 0, 0, "R8");
        run(15, L(2, 0), 0, 0, 0, 0, 0, "R13");
        run(4, L(8, 1) | 32'h4, 0, 0, 0, 0, 0, "R13");
        run(3, L(8, 1), 0, 0, 0, 0, 0, "R13");
        @(negedge clk);
        check("R13", !rsp_valid, 64'(rsp_valid), 64'd0);
        // random mix
        for (int n = 0; n < 900; n++) begin
            int r = $urandom_range(0, 21);
            int op = (r > 15) ? ((r < 19) ? 4 : 12) : r;
            run(op, L($urandom_range(1, 6), $urandom_range(0, 1)),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4),
                1'($urandom_range(0, 1)), $urandom_range(0, SETS * WAYS - 1),
                op_tag(op));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule